// File: doc/BRIEF.md
# Lockable Flash Configuration Register Bank

This block is the software-visible configuration store of a flash memory controller. It sits on a simple 32-bit register bus. Writes are accepted in one cycle. Read data is registered and appears in the cycle after the read strobe. The block holds several values and drives each of them out as a port:

- wait-state counts for the single-cycle (1T) and two-cycle (2T) access modes;
- one charge-pump trim word and two bank trim words;
- a trim-valid bit and a test-mode bit;
- a flash-block bit that stops user operations on the array;
- enables for the cache, the prefetcher and the micro-predictor.

Two read-only words are also mapped. One identifies the block and its revision. The other describes the bank count and the flash and ROM sizes.

Some bits are one-way. A lock bit comes out of reset set. While it is set, writes to the wait-state registers, the trim words, the trim-valid bit and the test-mode bit are dropped. Software clears the lock by writing 0 to it. After that it cannot be set again until reset. The flash-block bit works the other way round: once software writes 1 to it, it stays set until reset. The cache enables are never locked.

Top module: `flash_cfg_regs`

## Requirements
- R1: After an active-low synchronous reset, the registers hold these values: 1T and 2T wait states 7, pump trim 0x131A0000, both bank trims 0, flash-block 0, lock 1, trim-valid 0, test-mode 0, cache enables 3'b111, read data 0.
- R2: The identity word at offset 0x000 reads 0xD1400010 (module code 0xD140 in bits 31:16, register-offset nibble 0 in 15:12, instance index 0 in 11:8, major revision 1 in 7:4, minor revision 0 in 3:0). The size word at 0x004 reads 0x087FB000 (bank count 1 in bit 27, flash KB minus one 0x0FF in 26:15, ROM bytes 0x3000 in 14:0). Writes to either word are dropped.
- R3: When unlocked, the wait-state registers at 0x008 (1T) and 0x00C (2T) store wdata[2:0]. Their bits 31:3 read as zero.
- R4: The flash-block bit is bit 0 at offset 0x100. A write with bit 0 set makes it 1, and it then stays 1 until reset whatever is written.
- R5: The lock bit is bit 0 of the configuration word at 0x3FC. A write with bit 0 clear makes it 0, and it then stays 0 until reset.
- R6: While the lock is 1, writes to 0x008, 0x00C, the pump trim at 0x018 and the bank trims at 0x01C and 0x020 are dropped. When unlocked, the trim words take all 32 bits.
- R7: Trim-valid (bit 1 at 0x3FC) and test-mode (bit 2) are written only if the lock was already 0 before the write. A single write that clears the lock leaves them unchanged.
- R8: The enable word at 0x424 stores wdata[2:0] (bit 0 cache, bit 1 prefetch, bit 2 micro-predictor) whatever the lock state. Its bits 31:3 read as zero.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R10: rdata is loaded on the clock edge where rd_en is high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, accepted in one cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ws_1t | output | 3 | Wait states, 1T mode |
| ws_2t | output | 3 | Wait states, 2T mode |
| pump_trim | output | 32 | Charge-pump trim word |
| bank_trim1 | output | 32 | Bank trim word 1 |
| bank_trim0 | output | 32 | Bank trim word 0 |
| trim_ok | output | 1 | Trims marked valid |
| test_en | output | 1 | Flash test mode enable |
| locked | output | 1 | Lock bit state |
| flash_block | output | 1 | User flash operations blocked |
| cache_en | output | 3 | Micro-predictor, prefetch and cache enables |

## Verification
The bench writes every gated register while the block is locked. A design that gated on the wrong polarity, or left one register out of the group, would show the changed value on readback or on the output port. The bench also clears the lock with a write that sets trim-valid and test-mode in the same word. A design that checked the new lock value instead of the old one would set those bits early. After unlocking, the bench writes 1 back to the lock bit and writes 0 to a set flash-block bit, which catches registers that are not truly one-way. Finally, it reads the read-only words, unmapped offsets and the read-data hold cycle. These catch writable constants, stray decode hits, and read data that follows addr without waiting for the strobe.

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs #(
  parameter int          AW          = 12,
  parameter logic [3:0]  INST_IDX    = 4'h0,
  parameter logic        BANK_CNT    = 1'b1,
  parameter logic [11:0] FLASH_KB_M1 = 12'h0FF,
  parameter logic [14:0] ROM_BYTES   = 15'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [2:0]    ws_1t,
  output logic [2:0]    ws_2t,
  output logic [31:0]   pump_trim,
  output logic [31:0]   bank_trim1,
  output logic [31:0]   bank_trim0,
  output logic          trim_ok,
  output logic          test_en,
  output logic          locked,
  output logic          flash_block,
  output logic [2:0]    cache_en
);
  localparam logic [AW-1:0] A_ID   = AW'('h000);
  localparam logic [AW-1:0] A_SIZE = AW'('h004);
  localparam logic [AW-1:0] A_WS1  = AW'('h008);
  localparam logic [AW-1:0] A_WS2  = AW'('h00C);
  localparam logic [AW-1:0] A_PUMP = AW'('h018);
  localparam logic [AW-1:0] A_TRM1 = AW'('h01C);
  localparam logic [AW-1:0] A_TRM0 = AW'('h020);
  localparam logic [AW-1:0] A_BLK  = AW'('h100);
  localparam logic [AW-1:0] A_CFG  = AW'('h3FC);
  localparam logic [AW-1:0] A_CEN  = AW'('h424);
  localparam logic [31:0] ID_WORD   = {16'hD140, 4'h0, INST_IDX, 4'h1, 4'h0};
  localparam logic [31:0] SIZE_WORD = {4'h0, BANK_CNT, FLASH_KB_M1, ROM_BYTES};
  localparam logic [31:0] PUMP_RST  = 32'h131A_0000;

  logic [31:0] rd_word;
  logic        hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_1t       <= 3'd7;
      ws_2t       <= 3'd7;
      pump_trim   <= PUMP_RST;
      bank_trim1  <= '0;
      bank_trim0  <= '0;
      trim_ok     <= 1'b0;
      test_en     <= 1'b0;
      locked      <= 1'b1;
      flash_block <= 1'b0;
      cache_en    <= 3'b111;
    end else if (wr_en) begin
      case (addr)
        A_WS1:  if (!locked) ws_1t <= wdata[2:0];
        A_WS2:  if (!locked) ws_2t <= wdata[2:0];
        A_PUMP: if (!locked) pump_trim <= wdata;
        A_TRM1: if (!locked) bank_trim1 <= wdata;
        A_TRM0: if (!locked) bank_trim0 <= wdata;
        A_BLK:  if (wdata[0]) flash_block <= 1'b1;
        A_CFG: begin
          if (!wdata[0]) locked <= 1'b0;
          if (!locked) begin
            trim_ok <= wdata[1];
            test_en <= wdata[2];
          end
        end
        A_CEN:  cache_en <= wdata[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    hit     = 1'b1;
    rd_word = '0;
    case (addr)
      A_ID:   rd_word = ID_WORD;
      A_SIZE: rd_word = SIZE_WORD;
      A_WS1:  rd_word = {29'd0, ws_1t};
      A_WS2:  rd_word = {29'd0, ws_2t};
      A_PUMP: rd_word = pump_trim;
      A_TRM1: rd_word = bank_trim1;
      A_TRM0: rd_word = bank_trim0;
      A_BLK:  rd_word = {31'd0, flash_block};
      A_CFG:  rd_word = {29'd0, test_en, trim_ok, locked};
      A_CEN:  rd_word = {29'd0, cache_en};
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  p_block_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_block |=> flash_block);
  p_unlock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !locked);
  p_ws_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && (addr == A_WS1 || addr == A_WS2)) |=> ($stable(ws_1t) && $stable(ws_2t)));
  p_trim_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && (addr == A_PUMP || addr == A_TRM1 || addr == A_TRM0))
      |=> ($stable(pump_trim) && $stable(bank_trim1) && $stable(bank_trim0)));
  p_cfg_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && addr == A_CFG) |=> ($stable(trim_ok) && $stable(test_en)));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == 32'd0));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

// File: tb/test_flash_cfg_regs.sv
module test_flash_cfg_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pump_trim, bank_trim1, bank_trim0;
  logic [2:0]  ws_1t, ws_2t, cache_en;
  logic        trim_ok, test_en, locked, flash_block;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cfg_regs i_flash_cfg_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ws_1t(ws_1t), .ws_2t(ws_2t),
    .pump_trim(pump_trim), .bank_trim1(bank_trim1), .bank_trim0(bank_trim0),
    .trim_ok(trim_ok), .test_en(test_en), .locked(locked),
    .flash_block(flash_block), .cache_en(cache_en));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 locked port", {31'd0, locked}, 32'd1);
    chk("R1 cache port", {29'd0, cache_en}, 32'd7);
    rd_chk("R1 ws1", 12'h008, 32'd7);
    rd_chk("R1 ws2", 12'h00C, 32'd7);
    rd_chk("R1 pump", 12'h018, 32'h131A0000);
    rd_chk("R1 trim1", 12'h01C, 32'd0);
    rd_chk("R1 trim0", 12'h020, 32'd0);
    rd_chk("R1 block", 12'h100, 32'd0);
    rd_chk("R1 cfg", 12'h3FC, 32'd1);
    rd_chk("R1 cen", 12'h424, 32'd7);
  endtask

  task automatic t_readonly;
    wr(12'h000, 32'h0);
    wr(12'h004, 32'hFFFFFFFF);
    rd_chk("R2 id", 12'h000, {16'hD140, 4'h0, 4'h0, 4'h1, 4'h0});
    rd_chk("R2 size", 12'h004, {4'h0, 1'b1, 12'h0FF, 15'h3000});
  endtask

  task automatic t_locked;
    wr(12'h008, 32'd2);
    wr(12'h00C, 32'd3);
    wr(12'h018, 32'hDEADBEEF);
    wr(12'h01C, 32'h11111111);
    wr(12'h020, 32'h22222222);
    wr(12'h3FC, 32'h7);
    rd_chk("R6 ws1 locked", 12'h008, 32'd7);
    rd_chk("R6 ws2 locked", 12'h00C, 32'd7);
    rd_chk("R6 pump locked", 12'h018, 32'h131A0000);
    rd_chk("R6 trim1 locked", 12'h01C, 32'd0);
    rd_chk("R6 trim0 locked", 12'h020, 32'd0);
    chk("R6 ws1 port", {29'd0, ws_1t}, 32'd7);
    rd_chk("R7 cfg locked", 12'h3FC, 32'd1);
  endtask

  task automatic t_cache;
    wr(12'h424, 32'h2);
    rd_chk("R8 cen locked", 12'h424, 32'd2);
    wr(12'h424, 32'hFFFFFFFD);
    rd_chk("R8 cen reserved", 12'h424, 32'd5);
    chk("R8 cen port", {29'd0, cache_en}, 32'd5);
  endtask

  task automatic t_unlock;
    wr(12'h3FC, 32'h6);
    rd_chk("R7 clear-write no side bits", 12'h3FC, 32'd0);
    wr(12'h3FC, 32'h7);
    rd_chk("R5 lock stays 0", 12'h3FC, 32'd6);
    chk("R7 trim_ok port", {30'd0, test_en, trim_ok}, 32'd3);
    wr(12'h3FC, 32'h1);
    rd_chk("R7 bits clear", 12'h3FC, 32'd0);
    chk("R5 locked port", {31'd0, locked}, 32'd0);
  endtask

  task automatic t_unlocked_writes;
    wr(12'h008, 32'hFFFFFFF2);
    wr(12'h00C, 32'h5);
    wr(12'h018, 32'hA5A5C3C3);
    wr(12'h01C, 32'h12345678);
    wr(12'h020, 32'h9ABCDEF0);
    rd_chk("R3 ws1", 12'h008, 32'd2);
    rd_chk("R3 ws2", 12'h00C, 32'd5);
    chk("R3 ws2 port", {29'd0, ws_2t}, 32'd5);
    rd_chk("R6 pump open", 12'h018, 32'hA5A5C3C3);
    rd_chk("R6 trim1 open", 12'h01C, 32'h12345678);
    rd_chk("R6 trim0 open", 12'h020, 32'h9ABCDEF0);
    chk("R6 trim0 port", bank_trim0, 32'h9ABCDEF0);
  endtask

  task automatic t_block;
    wr(12'h100, 32'hFFFFFFFE);
    rd_chk("R4 block zero write", 12'h100, 32'd0);
    wr(12'h100, 32'h1);
    rd_chk("R4 block set", 12'h100, 32'd1);
    wr(12'h100, 32'h0);
    rd_chk("R4 block sticky", 12'h100, 32'd1);
    chk("R4 block port", {31'd0, flash_block}, 32'd1);
  endtask

  task automatic t_unmapped;
    wr(12'h200, 32'hFFFFFFFF);
    wr(12'h010, 32'hFFFFFFFF);
    rd_chk("R9 unmapped 0x200", 12'h200, 32'd0);
    rd_chk("R9 unmapped 0x010", 12'h010, 32'd0);
    rd_chk("R9 ws1 untouched", 12'h008, 32'd2);
    rd_chk("R9 cen untouched", 12'h424, 32'd5);
  endtask

  task automatic t_rd_timing;
    rd_chk("R10 id load", 12'h000, 32'hD1400010);
    @(negedge clk); addr = 12'h018;
    @(negedge clk);
    chk("R10 hold without strobe", rdata, 32'hD1400010);
    rd_en = 1'b1; addr = 12'h424;
    #1 chk("R10 not before edge", rdata, 32'hD1400010);
    @(negedge clk); rd_en = 1'b0;
    chk("R10 after edge", rdata, 32'd5);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_readonly;
    t_locked;
    t_cache;
    t_unlock;
    t_unlocked_writes;
    t_block;
    t_unmapped;
    t_rd_timing;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule